// File: doc/BRIEF.md
# Coin-Credit Lock Controller

This controller counts coin credit toward a fixed 15-cent price and releases a lock once that price is reached. A 5-cent coin and a 10-cent coin each arrive as a one-cycle pulse on a separate input. The controller keeps the running credit as one of four levels: 0, 5, 10 and 15 cents. Once full credit is reached, the unlock output stays high until a synchronous reset clears the credit.

The unlock output is not decoded from the stored credit. It is computed from the next-credit value in the same cycle that the credit register loads that value, and it is captured in its own flip-flop. Its decode therefore overlaps the next-state logic, yet the output still follows the exact cycle timing of a decode of the stored state.

Top module: `credit_lock_ctrl`

## Requirements
- R1: A clock edge with `rst` high clears the credit to 0 cents, and `unlock_o` is low after that edge.
- R2: A 5-cent pulse (`nickel_i`=1, `dime_i`=0) below full credit adds 5 cents, so three such pulses from 0 cents raise `unlock_o`.
- R3: A 10-cent pulse (`dime_i`=1) adds 10 cents: from 0 cents it gives 10 cents, and from 5 cents it gives full credit.
- R4: From 10 cents, either coin brings the credit to full, and `unlock_o` rises after that edge.
- R5: A cycle with neither coin input high leaves the credit unchanged, for any number of cycles.
- R6: At full credit, further coins of any kind have no effect: the credit stays full and `unlock_o` stays high until reset.
- R7: Both coin inputs high in the same cycle count as one 10-cent coin.
- R8: `unlock_o` is high exactly in the cycles where the stored credit is 15 cents. It rises right after the clock edge that stores full credit, with no extra cycle of delay.
- R9: Reset has priority over coins. Coin pulses during a reset cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | 5-cent coin pulse, one cycle per coin |
| dime_i | input | 1 | 10-cent coin pulse, one cycle per coin |
| unlock_o | output | 1 | Registered unlock, high while credit is full |

## Verification
The assertions check, on every cycle, that the registered unlock agrees with a decode of the stored credit. They also check the credit step for each coin class, that an idle cycle holds the credit, that full credit holds, and that reset clears both registers. The bench compares the unlock output each cycle with its own model of the credit, which it builds from the coin rules alone. Only the bench's scenarios can show the unlock rising in the same cycle as the final coin rather than one cycle later. They also show that credit survives long idle gaps, that coins arriving during reset leave no trace, and that a simultaneous coin pair counts as 10 cents.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int CREDIT_W = 2;
    localparam int COIN_W   = 2;

    // Credit levels in increasing order; the encoding follows the credit.
    typedef enum logic [CREDIT_W-1:0] {
        CREDIT_0  = 2'b00,
        CREDIT_5  = 2'b01,
        CREDIT_10 = 2'b10,
        CREDIT_15 = 2'b11
    } credit_t;

    // Coin classified for one cycle; a large coin wins over a small one.
    typedef enum logic [COIN_W-1:0] {
        COIN_NONE  = 2'b00,
        COIN_SMALL = 2'b01,
        COIN_LARGE = 2'b10
    } coin_t;

    function automatic credit_t credit_advance(input credit_t cur, input coin_t coin);
        credit_t res;
        res = cur;
        unique case (cur)
            CREDIT_0: begin
                if (coin == COIN_SMALL)      res = CREDIT_5;
                else if (coin == COIN_LARGE) res = CREDIT_10;
            end
            CREDIT_5: begin
                if (coin == COIN_SMALL)      res = CREDIT_10;
                else if (coin == COIN_LARGE) res = CREDIT_15;
            end
            CREDIT_10: begin
                if (coin != COIN_NONE)       res = CREDIT_15;
            end
            default: res = CREDIT_15;
        endcase
        return res;
    endfunction

    function automatic logic credit_unlocks(input credit_t c);
        return c == CREDIT_15;
    endfunction

endpackage

// File: rtl/coin_classify.sv
module coin_classify
    import lock_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_t coin_o
);

    always_comb begin
        if (dime_i)
            coin_o = COIN_LARGE;
        else if (nickel_i)
            coin_o = COIN_SMALL;
        else
            coin_o = COIN_NONE;
    end

endmodule

// File: rtl/credit_next.sv
module credit_next
    import lock_pkg::*;
(
    input  credit_t cur_i,
    input  coin_t   coin_i,
    output credit_t nxt_o
);

    always_comb begin
        nxt_o = credit_advance(cur_i, coin_i);
    end

endmodule

// File: rtl/unlock_retime.sv
module unlock_retime
    import lock_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_t nxt_i,
    output logic    unlock_q
);

    logic unlock_d;

    // Decode is taken from the next credit, in parallel with the credit load.
    always_comb begin
        unlock_d = credit_unlocks(nxt_i);
    end

    always_ff @(posedge clk) begin
        if (rst)
            unlock_q <= 1'b0;
        else
            unlock_q <= unlock_d;
    end

endmodule

// File: rtl/credit_lock_ctrl.sv
module credit_lock_ctrl
    import lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic unlock_o
);

    coin_t   coin;
    credit_t credit_q;
    credit_t credit_nxt;

    coin_classify u_classify (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    credit_next u_next (
        .cur_i  (credit_q),
        .coin_i (coin),
        .nxt_o  (credit_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            credit_q <= CREDIT_0;
        else
            credit_q <= credit_nxt;
    end

    unlock_retime u_unlock (
        .clk      (clk),
        .rst      (rst),
        .nxt_i    (credit_nxt),
        .unlock_q (unlock_o)
    );

endmodule

// File: rtl/credit_lock_checker.sv
module credit_lock_checker
    import lock_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    nickel_i,
    input logic    dime_i,
    input logic    unlock_o,
    input credit_t credit
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (credit == CREDIT_0) && !unlock_o); // R1

    AST_SMALL_STEP: assert property (@(posedge clk) disable iff (rst)
        (nickel_i && !dime_i && credit == CREDIT_0) |=> credit == CREDIT_5); // R2

    AST_SMALL_STEP_MID: assert property (@(posedge clk) disable iff (rst)
        (nickel_i && !dime_i && credit == CREDIT_5) |=> credit == CREDIT_10); // R2

    AST_LARGE_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dime_i && credit == CREDIT_0) |=> credit == CREDIT_10); // R3

    AST_LARGE_FROM_FIVE: assert property (@(posedge clk) disable iff (rst)
        (dime_i && credit == CREDIT_5) |=> credit == CREDIT_15); // R3

    AST_ANY_FROM_TEN: assert property (@(posedge clk) disable iff (rst)
        ((nickel_i || dime_i) && credit == CREDIT_10) |=> credit == CREDIT_15); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!nickel_i && !dime_i) |=> $stable(credit)); // R5

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (credit == CREDIT_15) |=> (credit == CREDIT_15) && unlock_o); // R6

    AST_UNLOCK_MATCHES: assert property (@(posedge clk) disable iff (rst)
        unlock_o == (credit == CREDIT_15)); // R8

endmodule

bind credit_lock_ctrl credit_lock_checker u_checker (
    .clk      (clk),
    .rst      (rst),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .unlock_o (unlock_o),
    .credit   (credit_q)
);

// File: tb/test_credit_lock_ctrl.sv
module test_credit_lock_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic unlock_o;

    int checks = 0;
    int errors = 0;
    int ref_cents = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    credit_lock_ctrl i_credit_lock_ctrl (
        .clk      (clk),
        .rst      (rst),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .unlock_o (unlock_o)
    );

    // Row fields: [7] rst, [6] 5-cent, [5] 10-cent, [4] expected unlock, [3:0] requirement number
    localparam int NVEC = 27;
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'b1000_0001, // R1 reset
        8'b0100_0010, // R2 5
        8'b0000_0101, // R5 hold 5
        8'b0100_0010, // R2 10
        8'b0000_0101, // R5 hold 10
        8'b0101_1000, // R8 15, unlock same edge
        8'b0001_0110, // R6 hold full
        8'b0101_0110, // R6 coin at full
        8'b0011_0110, // R6 large coin at full
        8'b0111_0110, // R6 both at full
        8'b1000_0001, // R1 reset from full
        8'b0010_0011, // R3 0 -> 10
        8'b0101_0100, // R4 10 -> 15 by small coin
        8'b1110_1001, // R9 reset beats coins
        8'b0100_0010, // R2 5
        8'b0011_0011, // R3 5 -> 15
        8'b1000_0001, // R1
        8'b0110_0111, // R7 both from 0 -> 10
        8'b0000_0111, // R7 still 10
        8'b0101_0111, // R7 small coin completes
        8'b1000_0001, // R1
        8'b0100_0010, // R2 5
        8'b0111_0111, // R7 both from 5 -> 15
        8'b1000_0001, // R1
        8'b0010_0011, // R3 10
        8'b0011_0100, // R4 10 -> 15 by large coin
        8'b1000_0001  // R1
    };

    task automatic model_step(input logic r, input logic n, input logic d);
        if (r)
            ref_cents = 0;
        else if (ref_cents < 15) begin
            if (d)      ref_cents = (ref_cents + 10 > 15) ? 15 : ref_cents + 10;
            else if (n) ref_cents = ref_cents + 5;
        end
    endtask

    task automatic check(input int req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL R%0d: unlock_o=%b expected=%b at %0t", req, actual, expected, $time);
        end
    endtask

    // Drive on the falling edge, sample just after the rising edge.
    task automatic cycle(input logic r, input logic n, input logic d);
        @(negedge clk);
        rst = r; nickel_i = n; dime_i = d;
        @(posedge clk);
        model_step(r, n, d);
        #1;
    endtask

    initial begin
        // R1: reset state after the first edge
        cycle(1'b1, 1'b0, 1'b0);
        check(1, unlock_o, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            cycle(VEC[i][7], VEC[i][6], VEC[i][5]);
            check(int'(VEC[i][3:0]), unlock_o, VEC[i][4]);
            check(8, unlock_o, ref_cents >= 15); // R8 against Moore-decoded model
        end

        // R5: credit survives a long idle gap
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            cycle(1'b0, 1'b0, 1'b0);
            check(5, unlock_o, 1'b0);
        end
        cycle(1'b0, 1'b0, 1'b1);
        check(5, unlock_o, 1'b1);

        // R9: coins during a held reset leave no credit
        for (int i = 0; i < 4; i++) begin
            cycle(1'b1, 1'b1, 1'b1);
            check(9, unlock_o, 1'b0);
        end
        cycle(1'b0, 1'b1, 1'b0);
        check(9, unlock_o, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);
        check(2, unlock_o, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);
        check(2, unlock_o, 1'b1);

        // R6: full credit held for many cycles with mixed coins
        for (int i = 0; i < 8; i++) begin
            cycle(1'b0, i[0], i[1]);
            check(6, unlock_o, 1'b1);
        end
        cycle(1'b1, 1'b0, 1'b0);
        check(1, unlock_o, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule